// File: doc/BRIEF.md
# Low-Power State Snoop Controller

This block follows the idle power state of a processor core and briefly leaves that state to service coherence snoops on the shared bus. From the running state the core can drop into halt, into the extended halt with its lower ratio and voltage point, or into stop-grant. From stop-grant it can sink further into deeper sleep. A wake event brings it back to running.

While the core sits in halt, extended halt or stop-grant, a snoop-start pulse moves the machine into one of three snoop-service states. There is one snoop-service state for each origin. The machine stays there until a serviced pulse arrives. That pulse may come from this agent or from any other agent on the bus. The machine then returns to the idle state it came from, so each origin is tracked by its own snoop-service state and needs no separate return register.

All outputs are registered. A registered state code, a snoop-in-progress flag and an active-low reduced-power indicator for the voltage regulator are driven from the same flop bank. The indicator is gated so that it can assert only in deeper sleep.

Top module: `lps_snoop_ctrl`

## Requirements
- R1: While reset is applied and on the first cycle after it, the state code is 0 (running), `snoop_busy` is 0 and `psi_n` is 1.
- R2: In running (code 0), a stop-grant request moves to stop-grant (code 3). Otherwise a halt request moves to halt (code 1) when `xhalt_en` is 0, or to extended halt (code 2) when it is 1. Stop-grant takes priority over halt.
- R3: A snoop-start pulse without wake moves the machine to a snoop-service state that depends on where it was. Halt goes to code 5, extended halt to code 6 and stop-grant to code 7. `snoop_busy` is 1 in exactly these three codes.
- R4: A snoop-service state is held for as long as `snoop_done` is low. Both `snoop_start` and `wake` have no effect there.
- R5: On `snoop_done`, code 5 returns to 1, code 6 returns to 2 and code 7 returns to 3.
- R6: In stop-grant with no wake and no snoop-start, a deeper-sleep request moves to deeper sleep (code 4). A snoop-start in deeper sleep has no effect.
- R7: `psi_n` is 0 only in deeper sleep (code 4) and is 1 in every other state.
- R8: A wake in halt, extended halt, stop-grant or deeper sleep returns the machine to running on the next clock. Wake has priority over snoop-start and over deeper-sleep requests.
- R9: In running, `snoop_start`, `snoop_done`, `wake`, `xhalt_en` and `dsleep_req` alone have no effect. Outside the snoop-service states, `snoop_done` has no effect.
- R10: Every output takes its new value one clock after the edge that samples the causing inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Request to enter halt |
| stpgnt_req | input | 1 | Request to enter stop-grant |
| xhalt_en | input | 1 | Selects extended halt on halt entry |
| dsleep_req | input | 1 | Request to sink from stop-grant to deeper sleep |
| wake | input | 1 | Break or wake event |
| snoop_start | input | 1 | A bus snoop begins |
| snoop_done | input | 1 | The snoop was serviced by any bus agent |
| state_code | output | 3 | Registered current state code |
| snoop_busy | output | 1 | A snoop is being serviced |
| psi_n | output | 1 | Active-low reduced-power indicator |

## Verification
A wrong internal state shows on `state_code` one clock after the edge that caused it, and `snoop_busy` and `psi_n` show it in the same cycle. A lost return origin appears as a wrong code on the cycle after `snoop_done`. The bench drives each of the eight states in turn and then applies all 128 combinations of the seven control inputs to it for one clock. Every code, flag and indicator is compared with a model built from the requirements.

// File: rtl/lps_pkg.sv
package lps_pkg;
    localparam int STW = 3;

    typedef enum logic [STW-1:0] {
        ST_RUN       = 3'd0,
        ST_HALT      = 3'd1,
        ST_XHALT     = 3'd2,
        ST_STPG      = 3'd3,
        ST_DEEP      = 3'd4,
        ST_SNP_HALT  = 3'd5,
        ST_SNP_XHALT = 3'd6,
        ST_SNP_STPG  = 3'd7
    } lps_state_e;

    typedef struct packed {
        lps_state_e state;
        logic       busy;
        logic       psi_n;
    } lps_regs_t;

    function automatic logic is_snoop(lps_state_e s);
        return (s == ST_SNP_HALT) || (s == ST_SNP_XHALT) || (s == ST_SNP_STPG);
    endfunction
endpackage

// File: rtl/lps_next_state.sv
module lps_next_state
    import lps_pkg::*;
(
    input  lps_state_e cur,
    input  logic       halt_req,
    input  logic       stpgnt_req,
    input  logic       xhalt_en,
    input  logic       dsleep_req,
    input  logic       wake,
    input  logic       snoop_start,
    input  logic       snoop_done,
    output lps_state_e nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_RUN: begin
                if (stpgnt_req)    nxt = ST_STPG;
                else if (halt_req) nxt = xhalt_en ? ST_XHALT : ST_HALT;
            end
            ST_HALT: begin
                if (wake)             nxt = ST_RUN;
                else if (snoop_start) nxt = ST_SNP_HALT;
            end
            ST_XHALT: begin
                if (wake)             nxt = ST_RUN;
                else if (snoop_start) nxt = ST_SNP_XHALT;
            end
            ST_STPG: begin
                if (wake)             nxt = ST_RUN;
                else if (snoop_start) nxt = ST_SNP_STPG;
                else if (dsleep_req)  nxt = ST_DEEP;
            end
            ST_DEEP: begin
                if (wake) nxt = ST_RUN;
            end
            ST_SNP_HALT: begin
                if (snoop_done) nxt = ST_HALT;
            end
            ST_SNP_XHALT: begin
                if (snoop_done) nxt = ST_XHALT;
            end
            ST_SNP_STPG: begin
                if (snoop_done) nxt = ST_STPG;
            end
            default: nxt = ST_RUN;
        endcase
    end
endmodule

// File: rtl/lps_out_map.sv
module lps_out_map
    import lps_pkg::*;
(
    input  lps_state_e st,
    output logic       busy,
    output logic       psi_n
);
    always_comb begin
        busy  = is_snoop(st);
        psi_n = (st != ST_DEEP);
    end
endmodule

// File: rtl/lps_snoop_ctrl.sv
module lps_snoop_ctrl
    import lps_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           halt_req,
    input  logic           stpgnt_req,
    input  logic           xhalt_en,
    input  logic           dsleep_req,
    input  logic           wake,
    input  logic           snoop_start,
    input  logic           snoop_done,
    output logic [STW-1:0] state_code,
    output logic           snoop_busy,
    output logic           psi_n
);
    lps_regs_t  r_d, r_q;
    lps_state_e nxt_state;
    logic       nxt_busy, nxt_psi_n;

    lps_next_state u_next (
        .cur         (r_q.state),
        .halt_req    (halt_req),
        .stpgnt_req  (stpgnt_req),
        .xhalt_en    (xhalt_en),
        .dsleep_req  (dsleep_req),
        .wake        (wake),
        .snoop_start (snoop_start),
        .snoop_done  (snoop_done),
        .nxt         (nxt_state)
    );

    lps_out_map u_map (
        .st    (nxt_state),
        .busy  (nxt_busy),
        .psi_n (nxt_psi_n)
    );

    always_comb begin
        r_d       = r_q;
        r_d.state = nxt_state;
        r_d.busy  = nxt_busy;
        r_d.psi_n = nxt_psi_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_RUN;
            r_q.busy  <= 1'b0;
            r_q.psi_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_code = r_q.state;
    assign snoop_busy = r_q.busy;
    assign psi_n      = r_q.psi_n;

    // R7: indicator low only in deeper sleep
    p_psi_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!psi_n) |-> (state_code == 3'd4));

    // R4: snoop-service state held until serviced
    p_snoop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_busy && !snoop_done) |=> (snoop_busy && $stable(state_code)));

    // R5: return to the origin state
    p_return_xhalt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd6 && snoop_done) |=> (state_code == 3'd2));

    // R8: wake from a non-snoop idle state
    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 3'd0 && !snoop_busy && wake) |=> (state_code == 3'd0));

    // R3: snoop entry from stop-grant
    p_snoop_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd3 && snoop_start && !wake) |=> (state_code == 3'd7 && snoop_busy));
endmodule

// File: tb/lps_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module lps_snoop_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 0, stpgnt_req = 0, xhalt_en = 0, dsleep_req = 0;
    logic wake = 0, snoop_start = 0, snoop_done = 0;
    logic [2:0] state_code;
    logic snoop_busy, psi_n;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lps_snoop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stpgnt_req(stpgnt_req),
        .xhalt_en(xhalt_en), .dsleep_req(dsleep_req), .wake(wake),
        .snoop_start(snoop_start), .snoop_done(snoop_done),
        .state_code(state_code), .snoop_busy(snoop_busy), .psi_n(psi_n)
    );

    // vector bits: 6 wake, 5 dsleep, 4 stpgnt, 3 halt, 2 xhalt_en, 1 snoop_start, 0 snoop_done
    task automatic drive(input logic [6:0] v);
        {wake, dsleep_req, stpgnt_req, halt_req, xhalt_en, snoop_start, snoop_done} = v;
    endtask

    function automatic logic [2:0] model(input logic [2:0] s, input logic [6:0] v);
        logic w, ds, sg, h, x, ss, sd;
        {w, ds, sg, h, x, ss, sd} = v;
        case (s)
            3'd0: return sg ? 3'd3 : (h ? (x ? 3'd2 : 3'd1) : 3'd0);
            3'd1, 3'd2: return w ? 3'd0 : (ss ? s + 3'd4 : s);
            3'd3: return w ? 3'd0 : (ss ? 3'd7 : (ds ? 3'd4 : 3'd3));
            3'd4: return w ? 3'd0 : 3'd4;
            default: return sd ? s - 3'd4 : s;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] exp_s);
        logic exp_b, exp_p;
        exp_b = (exp_s >= 3'd5);
        exp_p = (exp_s != 3'd4);
        checks++;
        if (state_code !== exp_s || snoop_busy !== exp_b || psi_n !== exp_p) begin
            errors++;
            $display("FAIL %s: state %0d busy %0b psi_n %0b, expected state %0d busy %0b psi_n %0b",
                     req, state_code, snoop_busy, psi_n, exp_s, exp_b, exp_p);
        end
    endtask

    // apply v on negedge, sample at the following negedge (one register)
    task automatic step(input logic [6:0] v);
        @(negedge clk);
        drive(v);
        @(negedge clk);
        drive(7'd0);
    endtask

    task automatic goto(input logic [2:0] t);
        @(negedge clk);
        drive(7'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        case (t)
            3'd1: step(7'b0001000);
            3'd2: step(7'b0001100);
            3'd3: step(7'b0010000);
            3'd4: begin step(7'b0010000); step(7'b0100000); end
            3'd5: begin step(7'b0001000); step(7'b0000010); end
            3'd6: begin step(7'b0001100); step(7'b0000010); end
            3'd7: begin step(7'b0010000); step(7'b0000010); end
            default: ;
        endcase
        check("R2 R3 R6 setup", t);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: during and right after reset
        repeat (2) @(negedge clk);
        check("R1 in reset", 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 3'd0);
        // R10: outputs do not move before the sampling edge
        @(negedge clk);
        drive(7'b0010000);
        #1;
        check("R10 no early change", 3'd0);
        @(negedge clk);
        drive(7'd0);
        check("R10 one-cycle latency", 3'd3);

        // sweep: every state x every input vector (R2..R9)
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 128; v++) begin
                goto(3'(s));
                step(7'(v));
                if (s >= 5)      check("R4 R5 snoop state", model(3'(s), 7'(v)));
                else if (s == 0) check("R2 R9 running", model(3'(s), 7'(v)));
                else             check("R3 R6 R7 R8 idle", model(3'(s), 7'(v)));
            end
        end

        // R4: a long hold with repeated snoop_start and wake
        goto(3'd5);
        for (int k = 0; k < 6; k++) begin
            step(7'b1000010);
            check("R4 held", 3'd5);
        end
        step(7'b0000001);
        check("R5 back to halt", 3'd1);
        step(7'b0000001);
        check("R9 done outside snoop", 3'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule